// File: doc/BRIEF.md
# Tag-Sorting Receive Queue Unit

This unit sits between the local delivery port of an on-chip mesh network and the processor of a node. Each arriving packet opens with a header word, whose length field gives the number of payload words. The next word is a tag that identifies the sender, the stream and the kind of message. The unit compares that tag with a set of per-queue tag values and their enable bits. It then writes the payload of the packet into the dedicated hardware queue whose tag matches, so software finds each stream already sorted.

A packet whose tag matches no enabled queue goes to a catch-all queue, with its tag word kept so that software can see who sent it. While the catch-all queue holds anything, an interrupt line stays high. The processor pops words one at a time through a simple read port. A read gets its answer on the next cycle, and a read of an empty queue reports a not-valid status instead of waiting. When the queue chosen for a word is full, the unit holds back its input and drops nothing.

The number of matching queues is a parameter (4 by default, 2 for a smaller network). By default the 128 words of receive storage are split statically: 24 words for each matching queue and 32 words for the catch-all queue.

Top module: `rx_tag_sorter`

## Requirements
- R1: After reset, `in_ready` is high, `ca_irq` and `rd_done` are low, and every queue reads as empty. A packet is a header word, then a tag word, then L payload words, where L is the header word's bits [7:0] (0 to 255). The other header bits are ignored.
- R2: Queue q (0 to NQ-1) matches when `cfg_en[q]` is 1 and the tag word equals `cfg_tag[q*32 +: 32]`. The payload of a matching packet is stored in queue q in arrival order, and the tag word is not stored.
- R3: When several enabled queues match the same tag, the queue with the lowest index receives the packet.
- R4: A tag that matches no enabled queue sends the packet to the catch-all queue, which has index NQ. The tag word is stored first, followed by the payload. A queue whose enable bit is 0 never matches, even when its tag is equal.
- R5: `ca_irq` is high exactly while the catch-all queue holds at least one word.
- R6: When the queue that the next word is steered to is full, `in_ready` is low and the word waits. It is accepted once a word has been popped from that queue, and no word is lost or reordered.
- R7: With L = 0, a matching packet stores nothing and a missing packet stores only its tag. The word after the tag is taken as a new header.
- R8: A matching queue holds exactly MQ_DEPTH (24) words and the catch-all queue holds exactly CA_DEPTH (32) words before it applies backpressure.
- R9: A read request (`rd_en` high with `rd_sel` set in cycle t) gives `rd_done` = 1 in cycle t+1. When the queue is non-empty, that cycle also gives `rd_ok` = 1 and `rd_data` = the oldest word of the queue, and the word is removed from the queue.
- R10: A read of an empty queue, or with `rd_sel` > NQ, gives `rd_done` = 1, `rd_ok` = 0 and `rd_data` = 0, with no stall and no change to any queue.
- R11: Header words and tag words of matching packets are always accepted (`in_ready` high), even when every queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming network word is valid |
| in_data | input | 32 | Incoming network word |
| in_ready | output | 1 | Unit accepts the word this cycle |
| cfg_tag | input | NQ*32 | Tag value per matching queue; queue q uses bits [q*32 +: 32] |
| cfg_en | input | NQ | Enable bit per matching queue |
| rd_en | input | 1 | Pop request from the processor |
| rd_sel | input | $clog2(NQ+1) | Queue to pop; NQ selects the catch-all queue |
| rd_done | output | 1 | Read response valid, one cycle after the request |
| rd_ok | output | 1 | Response carries a word; 0 means the queue was empty or the selection was invalid |
| rd_data | output | 32 | Popped word, or 0 when rd_ok is 0 |
| ca_irq | output | 1 | Catch-all queue is non-empty |

## Verification
The bench aims at the points where steering tends to go wrong. A duplicated tag on two enabled queues catches a priority encoder that favours the wrong index. A disabled queue with a matching tag catches a design that ignores the enable bit and pulls a stream out of the catch-all. Zero-length packets catch an off-by-one in the length counter, which would swallow the next header as payload. Filling a queue to exactly its depth and then holding a word against it catches a design that drops or overwrites a word at the boundary, or that stalls header and tag words needlessly. Reads of empty and non-existent queues must come back with the not-valid status and zero data, without popping anything.

// File: rtl/rxsort_pkg.sv
package rxsort_pkg;

    localparam int DATA_W = 32;
    localparam int LEN_W  = 8;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_TAG  = 2'd1,
        ST_BODY = 2'd2
    } steer_st_e;

    typedef struct packed {
        logic              done;
        logic              ok;
        logic [DATA_W-1:0] data;
    } rd_rsp_t;

    function automatic logic [LEN_W-1:0] hdr_len(input logic [DATA_W-1:0] w);
        return w[LEN_W-1:0];
    endfunction

endpackage

// File: rtl/rxsort_fifo.sv
module rxsort_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign rdata = mem[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
endmodule

// File: rtl/rxsort_match.sv
module rxsort_match #(
    parameter int NQ = 4,
    parameter int DW = 32,
    parameter int QW = 3
) (
    input  logic [DW-1:0]    tag,
    input  logic [NQ*DW-1:0] cfg_tag,
    input  logic [NQ-1:0]    cfg_en,
    output logic             hit,
    output logic [QW-1:0]    idx
);
    logic [NQ-1:0] eq;

    for (genvar g = 0; g < NQ; g++) begin : g_cmp
        assign eq[g] = cfg_en[g] && (cfg_tag[g*DW +: DW] == tag);
    end

    // lowest index wins: scan downwards so the last write is the lowest hit
    always_comb begin
        idx = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (eq[i]) idx = QW'(i);
        end
    end

    assign hit = |eq;
endmodule

// File: rtl/rxsort_steer.sv
module rxsort_steer
    import rxsort_pkg::*;
#(
    parameter int NQ = 4,
    parameter int QW = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_data,
    output logic                 in_ready,
    input  logic [NQ*DATA_W-1:0] cfg_tag,
    input  logic [NQ-1:0]        cfg_en,
    input  logic [NQ:0]          full_v,
    output logic [NQ:0]          push_v,
    output logic [DATA_W-1:0]    push_data
);
    steer_st_e        st;
    logic [LEN_W-1:0] remain;
    logic [QW-1:0]    dest;
    logic             hit;
    logic [QW-1:0]    hit_idx;
    logic             acc;

    rxsort_match #(.NQ(NQ), .DW(DATA_W), .QW(QW)) u_match (
        .tag     (in_data),
        .cfg_tag (cfg_tag),
        .cfg_en  (cfg_en),
        .hit     (hit),
        .idx     (hit_idx)
    );

    always_comb begin
        in_ready  = 1'b0;
        push_v    = '0;
        push_data = in_data;
        case (st)
            ST_HDR: in_ready = 1'b1;
            ST_TAG: begin
                if (hit) begin
                    in_ready = 1'b1;
                end else begin
                    in_ready   = !full_v[NQ];
                    push_v[NQ] = in_valid && !full_v[NQ];
                end
            end
            ST_BODY: begin
                in_ready     = !full_v[dest];
                push_v[dest] = in_valid && !full_v[dest];
            end
            default: in_ready = 1'b0;
        endcase
    end

    assign acc = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_HDR;
            remain <= '0;
            dest   <= '0;
        end else if (acc) begin
            case (st)
                ST_HDR: begin
                    remain <= hdr_len(in_data);
                    st     <= ST_TAG;
                end
                ST_TAG: begin
                    dest <= hit ? hit_idx : QW'(NQ);
                    st   <= (remain == '0) ? ST_HDR : ST_BODY;
                end
                ST_BODY: begin
                    remain <= remain - LEN_W'(1);
                    if (remain == LEN_W'(1)) st <= ST_HDR;
                end
                default: st <= ST_HDR;
            endcase
        end
    end
endmodule

// File: rtl/rx_tag_sorter.sv
module rx_tag_sorter
    import rxsort_pkg::*;
#(
    parameter int NQ       = 4,
    parameter int MQ_DEPTH = 24,
    parameter int CA_DEPTH = 32,
    parameter int QW       = $clog2(NQ + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_data,
    output logic                 in_ready,
    input  logic [NQ*DATA_W-1:0] cfg_tag,
    input  logic [NQ-1:0]        cfg_en,
    input  logic                 rd_en,
    input  logic [QW-1:0]        rd_sel,
    output logic                 rd_done,
    output logic                 rd_ok,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 ca_irq
);
    logic [NQ:0]       full_v, empty_v, push_v, pop_v;
    logic [DATA_W-1:0] push_data;
    logic [DATA_W-1:0] head [NQ+1];
    logic              sel_hit;
    logic [DATA_W-1:0] sel_data;
    rd_rsp_t           rsp;

    rxsort_steer #(.NQ(NQ), .QW(QW)) u_steer (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .cfg_tag   (cfg_tag),
        .cfg_en    (cfg_en),
        .full_v    (full_v),
        .push_v    (push_v),
        .push_data (push_data)
    );

    for (genvar g = 0; g <= NQ; g++) begin : g_q
        localparam int D = (g == NQ) ? CA_DEPTH : MQ_DEPTH;
        rxsort_fifo #(.DW(DATA_W), .DEPTH(D)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (push_v[g]),
            .wdata (push_data),
            .pop   (pop_v[g]),
            .rdata (head[g]),
            .full  (full_v[g]),
            .empty (empty_v[g])
        );
    end

    always_comb begin
        sel_data = '0;
        for (int i = 0; i <= NQ; i++) begin
            pop_v[i] = rd_en && (rd_sel == QW'(i)) && !empty_v[i];
            if (pop_v[i]) sel_data = head[i];
        end
        sel_hit = |pop_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.done <= rd_en;
            rsp.ok   <= sel_hit;
            rsp.data <= sel_data;
        end
    end

    assign rd_done = rsp.done;
    assign rd_ok   = rsp.ok;
    assign rd_data = rsp.data;
    assign ca_irq  = !empty_v[NQ];
endmodule

// File: rtl/rxsort_chk.sv
module rxsort_chk #(
    parameter int NQ = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic        rd_done,
    input logic        rd_ok,
    input logic [31:0] rd_data,
    input logic        ca_irq,
    input logic [NQ:0] full_v,
    input logic [NQ:0] push_v
);
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (push_v & full_v) == '0);

    assert_single_dest_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(push_v));

    assert_irq_on_catch_R5: assert property (@(posedge clk) disable iff (rst)
        push_v[NQ] |=> ca_irq);

    assert_rsp_next_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_done);

    assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_done);

    assert_empty_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !rd_ok) |-> (rd_data == 32'd0));
endmodule

bind rx_tag_sorter rxsort_chk #(.NQ(NQ)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_done (rd_done),
    .rd_ok   (rd_ok),
    .rd_data (rd_data),
    .ca_irq  (ca_irq),
    .full_v  (full_v),
    .push_v  (push_v)
);

// File: tb/sim_rx_tag_sorter.sv
`timescale 1ns/1ps
module sim_rx_tag_sorter;
    localparam int NQ = 4;
    localparam int CA = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [31:0]     in_data = '0;
    logic            in_ready;
    logic [NQ*32-1:0] cfg_tag = {32'hC2, 32'hC2, 32'hB1, 32'hA0};
    logic [NQ-1:0]   cfg_en = 4'b1111;
    logic            rd_en = 1'b0;
    logic [2:0]      rd_sel = '0;
    logic            rd_done, rd_ok, ca_irq;
    logic [31:0]     rd_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rx_tag_sorter u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .cfg_tag(cfg_tag), .cfg_en(cfg_en),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_done(rd_done), .rd_ok(rd_ok),
        .rd_data(rd_data), .ca_irq(ca_irq)
    );

    // packet vectors: {tag, length, expected queue}
    localparam logic [47:0] VEC [7] = '{
        {32'h0000_00A0, 8'd3, 8'd0},   // R2 queue 0
        {32'h0000_00B1, 8'd1, 8'd1},   // R2 queue 1
        {32'h0000_00C2, 8'd2, 8'd2},   // R3 tie between 2 and 3
        {32'h0000_0077, 8'd2, 8'd4},   // R4 miss
        {32'h0000_00A0, 8'd0, 8'd0},   // R7 empty matched
        {32'h0000_0055, 8'd0, 8'd4},   // R7 empty miss
        {32'h0000_00B1, 8'd5, 8'd1}    // R2 longer packet
    };

    task automatic chk(input bit cond, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic pop(input logic [2:0] s, output logic done, output logic ok,
                       output logic [31:0] d);
        @(negedge clk);
        rd_en  = 1'b1;
        rd_sel = s;
        @(negedge clk);
        rd_en = 1'b0;
        done  = rd_done;
        ok    = rd_ok;
        d     = rd_data;
    endtask

    task automatic expect_word(input logic [2:0] s, input logic [31:0] exp, input string req);
        logic dn, ok;
        logic [31:0] d;
        pop(s, dn, ok, d);
        chk(dn && ok && d == exp, req, d, exp);
    endtask

    task automatic expect_empty(input logic [2:0] s, input string req);
        logic dn, ok;
        logic [31:0] d;
        pop(s, dn, ok, d);
        chk(dn && !ok && d == 32'd0, req, {dn, ok, d[29:0]}, 32'h8000_0000);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready", {31'd0, in_ready}, 32'd1);
        chk(ca_irq == 1'b0, "R1 ca_irq", {31'd0, ca_irq}, 32'd0);
        chk(rd_done == 1'b0, "R1 rd_done", {31'd0, rd_done}, 32'd0);
        for (int q = 0; q <= NQ; q++) expect_empty(3'(q), "R1 empty after reset");

        // vector walk
        for (int v = 0; v < 7; v++) begin
            logic [31:0] tg;
            logic [7:0]  ln;
            logic [2:0]  eq;
            tg = VEC[v][47:16];
            ln = VEC[v][15:8];
            eq = VEC[v][2:0];
            send_word({16'h1234, 8'h00, ln});   // upper bits ignored (R1)
            send_word(tg);
            for (int k = 0; k < ln; k++) send_word(32'h5000_0000 | (v << 8) | k);
            @(negedge clk);
            if (eq == 3'(CA)) begin
                chk(ca_irq == 1'b1, "R5 irq raised", {31'd0, ca_irq}, 32'd1);
                expect_word(eq, tg, "R4 tag kept");
            end
            for (int k = 0; k < ln; k++)
                expect_word(eq, 32'h5000_0000 | (v << 8) | k, "R2 payload order");
            expect_empty(eq, "R7 nothing extra stored");
            @(negedge clk);
            chk(ca_irq == 1'b0, "R5 irq cleared", {31'd0, ca_irq}, 32'd0);
        end
        expect_empty(3'd3, "R3 higher index got nothing");

        // R10 invalid selection
        expect_empty(3'd7, "R10 invalid select");

        // R4 disabled queue never matches
        cfg_en = 4'b1110;
        send_word(32'h1);
        send_word(32'hA0);
        send_word(32'hD15A);
        expect_empty(3'd0, "R4 disabled queue empty");
        expect_word(3'(CA), 32'hA0, "R4 disabled tag to catch-all");
        expect_word(3'(CA), 32'hD15A, "R4 disabled payload");
        cfg_en = 4'b1111;

        // R8 / R6 / R11: fill queue 0 to its depth
        send_word(32'd24);
        send_word(32'hA0);
        for (int k = 0; k < 24; k++) send_word(32'hAA00_0000 + k);
        @(negedge clk);
        in_valid = 1'b1; in_data = 32'd2; #1;
        chk(in_ready == 1'b1, "R11 header with full queue", {31'd0, in_ready}, 32'd1);
        @(posedge clk); #1; in_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_data = 32'hA0; #1;
        chk(in_ready == 1'b1, "R11 tag with full queue", {31'd0, in_ready}, 32'd1);
        @(posedge clk); #1; in_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_data = 32'hBB00_0000; #1;
        chk(in_ready == 1'b0, "R8 queue holds 24", {31'd0, in_ready}, 32'd0);
        repeat (3) @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "R6 stall held", {31'd0, in_ready}, 32'd0);
        expect_word(3'd0, 32'hAA00_0000, "R6 oldest first");
        #1;
        chk(in_ready == 1'b1, "R6 resumes after pop", {31'd0, in_ready}, 32'd1);
        @(posedge clk); #1; in_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_data = 32'hBB00_0001; #1;
        chk(in_ready == 1'b0, "R6 full again", {31'd0, in_ready}, 32'd0);
        expect_word(3'd0, 32'hAA00_0001, "R6 second pop");
        @(posedge clk); #1; in_valid = 1'b0;
        for (int k = 2; k < 24; k++) expect_word(3'd0, 32'hAA00_0000 + k, "R6 no loss");
        expect_word(3'd0, 32'hBB00_0000, "R6 held word kept");
        expect_word(3'd0, 32'hBB00_0001, "R6 held word order");
        expect_empty(3'd0, "R6 drained");

        // R8 catch-all depth 32
        send_word(32'd31);
        send_word(32'h77);
        for (int k = 0; k < 31; k++) send_word(32'hC000_0000 + k);
        send_word(32'd0);
        @(negedge clk);
        in_valid = 1'b1; in_data = 32'h66; #1;
        chk(in_ready == 1'b0, "R8 catch-all holds 32", {31'd0, in_ready}, 32'd0);
        expect_word(3'(CA), 32'h77, "R8 catch-all tag");
        #1;
        chk(in_ready == 1'b1, "R6 catch-all resumes", {31'd0, in_ready}, 32'd1);
        @(posedge clk); #1; in_valid = 1'b0;
        for (int k = 0; k < 31; k++) expect_word(3'(CA), 32'hC000_0000 + k, "R8 catch-all order");
        expect_word(3'(CA), 32'h66, "R7 tag-only miss");
        expect_empty(3'(CA), "R10 catch-all empty");
        @(negedge clk);
        chk(ca_irq == 1'b0, "R5 irq low when empty", {31'd0, ca_irq}, 32'd0);

        finish_run();
    end
endmodule